// File: doc/BRIEF.md
# Non-preemptive vectored interrupt context controller

This block sits beside the pipeline of a small processor with an 8-bit datapath and takes care of four external interrupt request lines. Each line sets a pending bit. When the controller is idle and at least one bit is pending, it accepts the lowest-numbered request and clears that bit. It then stalls the pipeline while it copies the sixteen general registers and the program counter into a private scratchpad. In the last cycle of that copy it loads the program counter with the fixed entry address of the chosen service routine.

The service routine then runs with the pipeline released. A one-cycle return strobe starts the reverse sequence: the scratchpad contents are written back into the register file and the saved program counter is reloaded, so the interrupted program carries on where it stopped. Routines never nest. A request that arrives while a routine is active stays pending until the restore has finished.

The register file is read combinationally: the data for the address the block drives is expected in the same cycle. Register writes and program-counter loads take effect at the next rising clock edge.

Top module: `irq_ctx_ctrl`

## Requirements
- R1: Each of the four request inputs (bit k is request k, k = 0..3) sets its own pending bit when sampled high at a clock edge. The bit stays set until that request is accepted.
- R2: When several bits are pending at acceptance, the lowest-numbered request is accepted and only its pending bit is cleared. The other requests are served later, in ascending order.
- R3: The service entry address is 128 + 25·k for request k, which gives 128, 153, 178 and 203.
- R4: After acceptance, stall is high for exactly 17 cycles. In the first 16 of these cycles the register read address steps through 0 to 15 in order. In the 17th cycle the program counter is captured and the entry address is loaded.
- R5: A return strobe during a routine raises stall for exactly 17 cycles. In this time registers 0 to 15 get back their saved values and the program counter gets back the value it held when the save began.
- R6: A request raised while a routine is active, whether during the save or while the routine runs, causes no stall and no program-counter load until that routine's restore has finished.
- R7: A return strobe while no routine is active, or while a save is in progress, is ignored: no stall, no register write and no program-counter load follow from it.
- R8: A request still pending when a restore finishes is accepted once the controller is idle again. The pipeline is released for exactly one cycle between the restore and the next save.
- R9: Reset clears all pending bits and returns the controller to idle with stall, register write and program-counter load low. A request latched just before reset is never served.
- R10: During the save, the scratchpad stores the register file data that is present in the same cycle as the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 4 | Interrupt request lines, bit k = request k |
| rti_strobe | input | 1 | One-cycle return-from-routine strobe |
| rf_rd_addr | output | 4 | Register file read address during a save |
| rf_rd_data | input | 8 | Register file read data, combinational |
| rf_wr_en | output | 1 | Register file write enable during a restore |
| rf_wr_addr | output | 4 | Register file write address |
| rf_wr_data | output | 8 | Register file write data |
| pc_cur | input | 8 | Current program counter of the processor |
| pc_load | output | 1 | Load the program counter at the next edge |
| pc_load_val | output | 8 | Value to load into the program counter |
| stall | output | 1 | Pipeline hold during a save or a restore |

## Verification
The save and restore path is swept over every request line on its own. Each line gets a different register pattern, so a wrong vector, a shifted register index or a lost program counter shows up per line. Requests that arrive together in pairs and all four at once separate the priority order from the plain pending logic. A request injected during a running routine, and a return strobe given while idle or in the middle of a save, separate a correct non-nesting state machine from one that takes events in the wrong state. A request latched and then cleared by reset confirms that pending state does not survive reset.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

  typedef enum logic [1:0] {
    CTX_IDLE    = 2'd0,
    CTX_SAVE    = 2'd1,
    CTX_SERVE   = 2'd2,
    CTX_RESTORE = 2'd3
  } ctx_state_e;

  // Entry address of service routine idx: evenly spaced from a base.
  function automatic int entry_addr(input int idx, input int base, input int stride);
    return base + stride * idx;
  endfunction

  // Number of stalled cycles per save or restore: one per register plus the PC.
  function automatic int xfer_cycles(input int nregs);
    return nregs + 1;
  endfunction

endpackage

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
  parameter  int NREQ = 4,
  localparam int IW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] irq_req,
  input  logic            take,
  output logic [NREQ-1:0] pending,
  output logic            any_pend,
  output logic [NREQ-1:0] grant,
  output logic [IW-1:0]   grant_idx
);

  logic [NREQ-1:0] pend_q;
  logic [NREQ-1:0] clr_mask;
  logic            found;

  // Lowest-numbered pending request wins.
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    for (int k = 0; k < NREQ; k++) begin
      if (pend_q[k] && !found) begin
        grant[k]  = 1'b1;
        grant_idx = IW'(k);
        found     = 1'b1;
      end
    end
  end

  assign clr_mask = take ? grant : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | irq_req;
    end
  end

  assign pending  = pend_q;
  assign any_pend = |pend_q;

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_pkg::*;
#(
  parameter  int NREGS = 16,
  localparam int CW    = $clog2(NREGS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_pend,
  input  logic          rti_strobe,
  output ctx_state_e    state,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          stall,
  output logic          accept,
  output logic          rti_taken,
  output logic          save_step,
  output logic          save_last,
  output logic          rest_step,
  output logic          rest_last
);

  localparam logic [CW-1:0] LAST = CW'(xfer_cycles(NREGS) - 1);

  ctx_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign accept    = (state_q == CTX_IDLE) && any_pend;
  assign rti_taken = (state_q == CTX_SERVE) && rti_strobe;
  assign save_step = (state_q == CTX_SAVE) && (cnt_q != LAST);
  assign save_last = (state_q == CTX_SAVE) && (cnt_q == LAST);
  assign rest_step = (state_q == CTX_RESTORE) && (cnt_q != LAST);
  assign rest_last = (state_q == CTX_RESTORE) && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      CTX_IDLE: begin
        cnt_d = '0;
        if (accept) state_d = CTX_SAVE;
      end
      CTX_SAVE: begin
        if (save_last) begin
          state_d = CTX_SERVE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CTX_SERVE: begin
        cnt_d = '0;
        if (rti_taken) state_d = CTX_RESTORE;
      end
      CTX_RESTORE: begin
        if (rest_last) begin
          state_d = CTX_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = CTX_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTX_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;
  assign cnt   = cnt_q;
  assign busy  = (state_q != CTX_IDLE);
  assign stall = (state_q == CTX_SAVE) || (state_q == CTX_RESTORE);

endmodule

// File: rtl/irq_ctx_store.sv
module irq_ctx_store #(
  parameter  int NREGS = 16,
  parameter  int DW    = 8,
  parameter  int AW    = 8,
  localparam int RIW   = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RIW-1:0] reg_idx,
  input  logic [DW-1:0]  reg_din,
  output logic [DW-1:0]  reg_dout,
  input  logic           pc_we,
  input  logic [AW-1:0]  pc_din,
  output logic [AW-1:0]  pc_dout
);

  logic [DW-1:0] slot_q [NREGS];
  logic [AW-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) slot_q[i] <= '0;
      pc_q <= '0;
    end else begin
      if (reg_we) slot_q[reg_idx] <= reg_din;
      if (pc_we)  pc_q <= pc_din;
    end
  end

  assign reg_dout = slot_q[reg_idx];
  assign pc_dout  = pc_q;

endmodule

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl
  import irq_ctx_pkg::*;
#(
  parameter  int NREQ       = 4,
  parameter  int NREGS      = 16,
  parameter  int DW         = 8,
  parameter  int AW         = 8,
  parameter  int VEC_BASE   = 128,
  parameter  int VEC_STRIDE = 25,
  localparam int RIW        = $clog2(NREGS),
  localparam int IW         = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int CW         = $clog2(NREGS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] irq_req,
  input  logic            rti_strobe,
  output logic [RIW-1:0]  rf_rd_addr,
  input  logic [DW-1:0]   rf_rd_data,
  output logic            rf_wr_en,
  output logic [RIW-1:0]  rf_wr_addr,
  output logic [DW-1:0]   rf_wr_data,
  input  logic [AW-1:0]   pc_cur,
  output logic            pc_load,
  output logic [AW-1:0]   pc_load_val,
  output logic            stall
);

  // Named internal events, brought out for the checker.
  logic            ev_accept;
  logic            ev_rti_taken;
  logic            ev_save_done;
  logic            ev_restore_done;
  logic            busy;

  logic [NREQ-1:0] pending;
  logic            any_pend;
  logic [NREQ-1:0] grant;
  logic [IW-1:0]   grant_idx;
  ctx_state_e      state;
  logic [CW-1:0]   cnt;
  logic            save_step;
  logic            rest_step;
  logic [RIW-1:0]  slot_idx;
  logic [DW-1:0]   slot_dout;
  logic [AW-1:0]   saved_pc;
  logic [IW-1:0]   vec_idx_q;
  logic [AW-1:0]   vec_addr;

  irq_pend_arb #(.NREQ(NREQ)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .take      (ev_accept),
    .pending   (pending),
    .any_pend  (any_pend),
    .grant     (grant),
    .grant_idx (grant_idx)
  );

  irq_ctx_seq #(.NREGS(NREGS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_pend   (any_pend),
    .rti_strobe (rti_strobe),
    .state      (state),
    .cnt        (cnt),
    .busy       (busy),
    .stall      (stall),
    .accept     (ev_accept),
    .rti_taken  (ev_rti_taken),
    .save_step  (save_step),
    .save_last  (ev_save_done),
    .rest_step  (rest_step),
    .rest_last  (ev_restore_done)
  );

  assign slot_idx = cnt[RIW-1:0];

  irq_ctx_store #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (save_step),
    .reg_idx  (slot_idx),
    .reg_din  (rf_rd_data),
    .reg_dout (slot_dout),
    .pc_we    (ev_save_done),
    .pc_din   (pc_cur),
    .pc_dout  (saved_pc)
  );

  // Remember which routine was accepted until its save completes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_idx_q <= '0;
    end else if (ev_accept) begin
      vec_idx_q <= grant_idx;
    end
  end

  assign vec_addr    = AW'(entry_addr(int'(vec_idx_q), VEC_BASE, VEC_STRIDE));

  assign rf_rd_addr  = slot_idx;
  assign rf_wr_en    = rest_step;
  assign rf_wr_addr  = slot_idx;
  assign rf_wr_data  = slot_dout;

  assign pc_load     = ev_save_done || ev_restore_done;
  assign pc_load_val = ev_save_done ? vec_addr : saved_pc;

endmodule

// File: rtl/irq_ctx_ctrl_chk.sv
module irq_ctx_ctrl_chk #(
  parameter int NREQ  = 4,
  parameter int NREGS = 16,
  parameter int AW    = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rti_strobe,
  input logic [NREQ-1:0] pending,
  input logic [NREQ-1:0] grant,
  input logic            ev_accept,
  input logic            ev_save_done,
  input logic            busy,
  input logic            stall,
  input logic            rf_wr_en,
  input logic            pc_load,
  input logic [AW-1:0]   pc_load_val
);

  localparam int XFER = NREGS + 1;

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 0;
    else if (stall) run_q <= run_q + 1;
    else run_q <= 0;
  end

  // R4
  accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> stall);

  // R5
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && $past(stall)) |-> (run_q == XFER));

  // R4
  stall_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= XFER);

  // R2
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> ($onehot0(grant) && ((pending & (grant - 1'b1)) == '0) && (grant != '0)));

  // R3
  vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_save_done |-> (pc_load && (pc_load_val == AW'(128) || pc_load_val == AW'(153)
                               || pc_load_val == AW'(178) || pc_load_val == AW'(203))));

  // R6
  no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !busy);

  // R7
  rti_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_strobe && !busy && !ev_accept) |=> !stall);

  // R5
  wr_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en || pc_load) |-> stall);

endmodule

bind irq_ctx_ctrl irq_ctx_ctrl_chk #(.NREQ(NREQ), .NREGS(NREGS), .AW(AW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rti_strobe   (rti_strobe),
  .pending      (pending),
  .grant        (grant),
  .ev_accept    (ev_accept),
  .ev_save_done (ev_save_done),
  .busy         (busy),
  .stall        (stall),
  .rf_wr_en     (rf_wr_en),
  .pc_load      (pc_load),
  .pc_load_val  (pc_load_val)
);

// File: tb/irq_ctx_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctx_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_req = '0;
  logic       rti_strobe = 1'b0;
  logic [3:0] rf_rd_addr;
  logic [7:0] rf_rd_data;
  logic       rf_wr_en;
  logic [3:0] rf_wr_addr;
  logic [7:0] rf_wr_data;
  logic [7:0] pc_cur;
  logic       pc_load;
  logic [7:0] pc_load_val;
  logic       stall;

  logic [7:0] rf_m [16];
  logic       tb_we = 1'b0;
  logic [3:0] tb_waddr = '0;
  logic [7:0] tb_wdata = '0;
  logic [7:0] pc_m;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ctx_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .rti_strobe(rti_strobe),
    .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .pc_cur(pc_cur), .pc_load(pc_load), .pc_load_val(pc_load_val), .stall(stall)
  );

  // Processor model: register file and a program counter that runs when not stalled.
  assign rf_rd_data = rf_m[rf_rd_addr];
  assign pc_cur     = pc_m;

  always @(posedge clk) begin
    if (rf_wr_en) rf_m[rf_wr_addr] <= rf_wr_data;
    else if (tb_we) rf_m[tb_waddr] <= tb_wdata;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_m <= 8'd0;
    else if (pc_load) pc_m <= pc_load_val;
    else if (!stall) pc_m <= pc_m + 8'd1;
  end

  function automatic logic [7:0] pat(input int seed, input int r);
    return 8'((seed * 7) + (r * 29) + (r << 4) + 3);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill_regs(input int seed, input bit invert);
    for (int r = 0; r < 16; r++) begin
      tb_we    = 1'b1;
      tb_waddr = 4'(r);
      tb_wdata = invert ? ~pat(seed, r) : pat(seed, r);
      @(negedge clk);
    end
    tb_we = 1'b0;
  endtask

  task automatic pulse_irq(input logic [3:0] m);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic pulse_rti();
    rti_strobe = 1'b1;
    @(negedge clk);
    rti_strobe = 1'b0;
  endtask

  task automatic wait_stall(input string req);
    int t = 0;
    while (!stall && t < 60) begin
      @(negedge clk);
      t++;
    end
    check(stall, req, int'(stall), 1);
  endtask

  // Count stalled cycles; on a save, also check the read address order.
  task automatic run_stall(input bit is_save, input bit mid_rti, output int n);
    n = 0;
    while (stall && n < 40) begin
      if (is_save && n < 16)
        check(rf_rd_addr == 4'(n), "R4 read order", int'(rf_rd_addr), n);
      rti_strobe = (mid_rti && n == 3);
      @(negedge clk);
      n++;
    end
    rti_strobe = 1'b0;
  endtask

  logic [7:0] pc_at;

  task automatic enter(input int exp_vec, input bit mid_rti);
    int n;
    wait_stall("R1 accept");
    pc_at = pc_m;
    run_stall(1'b1, mid_rti, n);
    check(n == 17, "R4 save length", n, 17);
    check(pc_m == 8'(exp_vec), "R3 entry address", int'(pc_m), exp_vec);
  endtask

  task automatic leave(input int seed);
    int n;
    fill_regs(seed, 1'b1);
    pulse_rti();
    wait_stall("R5 restore start");
    run_stall(1'b0, 1'b0, n);
    check(n == 17, "R5 restore length", n, 17);
    check(pc_m == pc_at, "R5 resume pc", int'(pc_m), int'(pc_at));
    for (int r = 0; r < 16; r++)
      check(rf_m[r] == pat(seed, r), "R5 R10 register restored", int'(rf_m[r]), int'(pat(seed, r)));
  endtask

  task automatic quiet(input int cycles, input string req);
    for (int c = 0; c < cycles; c++) begin
      check(!stall && !pc_load && !rf_wr_en, req, int'(stall), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int r = 0; r < 16; r++) rf_m[r] = 8'd0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!stall && !pc_load && !rf_wr_en, "R9 reset outputs", int'(stall), 0);
    rst_n = 1'b1;
    @(negedge clk);
    quiet(3, "R9 idle after reset");

    // R1 R3 R4 R5: sweep each request line alone
    for (int i = 0; i < 4; i++) begin
      fill_regs(i * 41 + 5, 1'b0);
      pulse_irq(4'(1 << i));
      enter(128 + 25 * i, 1'b0);
      leave(i * 41 + 5);
      quiet(2, "R1 no spurious repeat");
    end

    // R2: pairs and all four at once
    fill_regs(90, 1'b0);
    pulse_irq(4'b1010);
    enter(153, 1'b0);
    leave(90);
    check(!stall, "R8 one idle cycle", int'(stall), 0);
    @(negedge clk);
    check(stall, "R8 pending taken after restore", int'(stall), 1);
    enter(203, 1'b0);
    leave(90);

    fill_regs(11, 1'b0);
    pulse_irq(4'b1111);
    for (int i = 0; i < 4; i++) begin
      enter(128 + 25 * i, 1'b0);
      leave(11);
    end
    quiet(3, "R2 all served once");

    // R6: request during an active routine waits
    fill_regs(60, 1'b0);
    pulse_irq(4'b0100);
    enter(178, 1'b0);
    pulse_irq(4'b0001);
    quiet(6, "R6 no nesting");
    leave(60);
    enter(128, 1'b0);
    leave(60);

    // R7: return strobe when idle
    fill_regs(77, 1'b0);
    pulse_rti();
    quiet(5, "R7 idle strobe ignored");
    for (int r = 0; r < 16; r++)
      check(rf_m[r] == pat(77, r), "R7 registers untouched", int'(rf_m[r]), int'(pat(77, r)));

    // R7: return strobe during a save is ignored
    pulse_irq(4'b1000);
    enter(203, 1'b1);
    quiet(6, "R7 strobe in save ignored");
    leave(77);

    // R9: request latched, then reset before acceptance
    irq_req = 4'b0010;
    @(posedge clk);
    #1 irq_req = '0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!stall, "R9 reset during pending", int'(stall), 0);
    rst_n = 1'b1;
    @(negedge clk);
    quiet(8, "R9 pending cleared");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule